// File: doc/BRIEF.md
# Paired-Page Translation Buffer

This block is a fully associative translation buffer that software loads. Each entry maps a pair of adjacent virtual pages, one even and one odd, onto two independent physical frames. A per-entry size mask sets the page size, from 4 KB upward. A lookup takes a 32-bit virtual address, the current 8-bit address-space ID and a read/write flag. It returns the physical address, the read and write permissions and a two-bit status. The lookup is purely combinational, so the result is valid in the same cycle as the request.

Entries are loaded through an indexed write port that takes the whole entry in one cycle. The written entry becomes visible to lookups after the next rising clock edge. Replacement policy is left to the caller. An entry matches when its global flag is set or its stored ID equals the current ID, and its virtual tag equals the address on every bit that the size mask leaves in play. When the tag hits, the valid and dirty flags of the selected half decide the result. An entry with valid clear gives "invalid", which differs from "no match" when no entry hits. A write to a clean page gives "modify fault".

Top module: `tlb_lookup`

## Requirements
- R1: After reset every entry is all zero: tag 0, ID 0, global 0, mask 0, both valid and dirty flags 0. A lookup of VA 0x0000_1000 with ID 0 therefore returns invalid, and the same address with ID 5 returns no match.
- R2: An entry matches only if its global flag is set or its stored ID equals `asid_i`. Otherwise the entry is skipped. When no entry matches, `status_o` is 1 (no match).
- R3: The tag is VA[31:13]. Mask bit k (`w_pmask_i[k]`) removes VA bit 13+k from the comparison, on both the address and the stored tag. The mask must be contiguous ones from bit 0: 0 gives 4 KB pages and 3 gives 16 KB pages.
- R4: The half is selected by VA bit 12+m, where m is the number of ones in the mask. A 0 selects the even half and a 1 selects the odd half.
- R5: If the selected half has valid clear, `status_o` is 2 (invalid).
- R6: A write access (`write_i`=1) to a valid half with dirty clear gives `status_o` 3 (modify fault). A read never gives 3.
- R7: On a hit, `status_o` is 0. `pa_o` is {PFN, 12'b0} ORed with the VA bits below bit 12+m. `rd_ok_o` is 1 and `wr_ok_o` equals the half's dirty flag.
- R8: Whenever `status_o` is not 0, `pa_o`, `rd_ok_o` and `wr_ok_o` are all 0.
- R9: When several entries match, the one with the lowest index decides the result.
- R10: With `we_i`=1, the entry at `widx_i` is replaced at the rising edge. Lookups see the new entry only after that edge. With `we_i`=0, the write fields have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Entry write strobe |
| widx_i | input | 3 | Entry index to write |
| w_vpn2_i | input | 19 | Virtual tag, VA[31:13] of the pair |
| w_asid_i | input | 8 | Address-space ID of the entry |
| w_global_i | input | 1 | Match regardless of ID |
| w_pmask_i | input | 16 | Page size mask |
| w_pfn_even_i | input | 20 | Even-half frame number |
| w_v_even_i | input | 1 | Even-half valid |
| w_d_even_i | input | 1 | Even-half dirty (writable) |
| w_pfn_odd_i | input | 20 | Odd-half frame number |
| w_v_odd_i | input | 1 | Odd-half valid |
| w_d_odd_i | input | 1 | Odd-half dirty (writable) |
| va_i | input | 32 | Lookup virtual address |
| asid_i | input | 8 | Current address-space ID |
| write_i | input | 1 | Lookup is a store |
| pa_o | output | 32 | Physical address |
| rd_ok_o | output | 1 | Read permitted |
| wr_ok_o | output | 1 | Write permitted |
| status_o | output | 2 | 0 hit, 1 no match, 2 invalid, 3 modify fault |

## Verification
Two situations are hardest to reach from the ports. The first is lowest-index priority, because the bench normally keeps entries disjoint. It loads two deliberately overlapping global entries at indices 1 and 6 and observes the frame of index 1. It then rewrites index 1 elsewhere and expects index 6's frame to appear. The second is the write-visibility boundary. The bench drives a write and a lookup to the new page in the same cycle, samples before the edge (expecting no match) and samples again after it (expecting a hit). The mask case uses an address whose bit 13 would break the tag compare if the mask were ignored.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W       = 32;
  localparam int PA_W       = 32;
  localparam int ASID_W     = 8;
  localparam int PAGE_SHIFT = 12;
  localparam int MASK_W     = 16;
  localparam int VPN2_W     = VA_W - PAGE_SHIFT - 1;
  localparam int PFN_W      = PA_W - PAGE_SHIFT;

  typedef enum logic [1:0] {
    ST_HIT     = 2'd0,
    ST_MISS    = 2'd1,
    ST_INVALID = 2'd2,
    ST_MODIFY  = 2'd3
  } tlb_status_e;

  typedef struct packed {
    logic [VPN2_W-1:0] vpn2;
    logic [ASID_W-1:0] asid;
    logic              glob;
    logic [MASK_W-1:0] pmask;
    logic [PFN_W-1:0]  pfn_e;
    logic              v_e;
    logic              d_e;
    logic [PFN_W-1:0]  pfn_o;
    logic              v_o;
    logic              d_o;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  tlb_entry_t       wdata_i,
  output tlb_entry_t       ent_o [N_ENT]
);
  tlb_entry_t ent_q [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   ent_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))          ent_q[g] <= wdata_i;
    end
    assign ent_o[g] = ent_q[g];
  end

  assert_write_lands_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ent_q[$past(widx_i)] == $past(wdata_i));
endmodule

// File: rtl/tlb_cmp.sv
module tlb_cmp
  import tlb_pkg::*;
(
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [VPN2_W-1:0] vpn2_i,
  input  logic [ASID_W-1:0] e_asid_i,
  input  logic              glob_i,
  input  logic [MASK_W-1:0] pmask_i,
  output logic              hit_o,
  output logic              odd_o,
  output logic [VA_W-1:0]   half_mask_o
);
  localparam int HI_PAD = VA_W - MASK_W - PAGE_SHIFT - 1;

  logic [VA_W-1:0]   cmp_mask;
  logic [VPN2_W-1:0] diff;
  logic              asid_ok;

  // ones below the pair boundary, mask bits above it
  assign cmp_mask    = {{HI_PAD{1'b0}}, pmask_i, {(PAGE_SHIFT+1){1'b1}}};
  assign half_mask_o = cmp_mask >> 1;
  assign diff        = (va_i[VA_W-1:PAGE_SHIFT+1] ^ vpn2_i) & ~cmp_mask[VA_W-1:PAGE_SHIFT+1];
  assign asid_ok     = glob_i || (e_asid_i == asid_i);
  assign hit_o       = asid_ok && (diff == '0);
  assign odd_o       = |(va_i & cmp_mask & ~half_mask_o);
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic [VA_W-1:0]  va_i,
  input  logic             write_i,
  input  logic [N_ENT-1:0] hit_i,
  input  logic [N_ENT-1:0] odd_i,
  input  logic [VA_W-1:0]  half_mask_i [N_ENT],
  input  logic [PFN_W-1:0] pfn_e_i [N_ENT],
  input  logic [PFN_W-1:0] pfn_o_i [N_ENT],
  input  logic [N_ENT-1:0] v_e_i,
  input  logic [N_ENT-1:0] v_o_i,
  input  logic [N_ENT-1:0] d_e_i,
  input  logic [N_ENT-1:0] d_o_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             rd_ok_o,
  output logic             wr_ok_o,
  output tlb_status_e      status_o
);
  logic             found;
  logic [IDX_W-1:0] sel;
  logic             odd, vld, dty;
  logic [PFN_W-1:0] pfn;
  logic [VA_W-1:0]  off;

  // scan downward so the lowest matching index is left in sel
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        found = 1'b1;
        sel   = IDX_W'(i);
      end
    end
  end

  always_comb begin
    odd = odd_i[sel];
    vld = odd ? v_o_i[sel] : v_e_i[sel];
    dty = odd ? d_o_i[sel] : d_e_i[sel];
    pfn = odd ? pfn_o_i[sel] : pfn_e_i[sel];
    off = va_i & half_mask_i[sel];
  end

  always_comb begin
    pa_o     = '0;
    rd_ok_o  = 1'b0;
    wr_ok_o  = 1'b0;
    status_o = ST_MISS;
    if (found) begin
      if (!vld)                 status_o = ST_INVALID;
      else if (write_i && !dty) status_o = ST_MODIFY;
      else begin
        status_o = ST_HIT;
        pa_o     = {pfn, {PAGE_SHIFT{1'b0}}} | PA_W'(off);
        rd_ok_o  = 1'b1;
        wr_ok_o  = dty;
      end
    end
  end
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int N_ENT = 8,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [VPN2_W-1:0] w_vpn2_i,
  input  logic [ASID_W-1:0] w_asid_i,
  input  logic              w_global_i,
  input  logic [MASK_W-1:0] w_pmask_i,
  input  logic [PFN_W-1:0]  w_pfn_even_i,
  input  logic              w_v_even_i,
  input  logic              w_d_even_i,
  input  logic [PFN_W-1:0]  w_pfn_odd_i,
  input  logic              w_v_odd_i,
  input  logic              w_d_odd_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              write_i,
  output logic [PA_W-1:0]   pa_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic [1:0]        status_o
);
  tlb_entry_t  wdata;
  tlb_entry_t  ent [N_ENT];
  logic [N_ENT-1:0] hit, odd, v_e, v_o, d_e, d_o;
  logic [VA_W-1:0]  half_mask [N_ENT];
  logic [PFN_W-1:0] pfn_e [N_ENT];
  logic [PFN_W-1:0] pfn_o [N_ENT];
  tlb_status_e st;

  assign wdata = '{vpn2: w_vpn2_i, asid: w_asid_i, glob: w_global_i, pmask: w_pmask_i,
                   pfn_e: w_pfn_even_i, v_e: w_v_even_i, d_e: w_d_even_i,
                   pfn_o: w_pfn_odd_i, v_o: w_v_odd_i, d_o: w_d_odd_i};

  tlb_store #(.N_ENT(N_ENT)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .widx_i(widx_i),
    .wdata_i(wdata), .ent_o(ent)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    tlb_cmp u_cmp (
      .va_i(va_i), .asid_i(asid_i),
      .vpn2_i(ent[g].vpn2), .e_asid_i(ent[g].asid), .glob_i(ent[g].glob),
      .pmask_i(ent[g].pmask),
      .hit_o(hit[g]), .odd_o(odd[g]), .half_mask_o(half_mask[g])
    );
    assign pfn_e[g] = ent[g].pfn_e;
    assign pfn_o[g] = ent[g].pfn_o;
    assign v_e[g]   = ent[g].v_e;
    assign v_o[g]   = ent[g].v_o;
    assign d_e[g]   = ent[g].d_e;
    assign d_o[g]   = ent[g].d_o;
  end

  tlb_resolve #(.N_ENT(N_ENT)) u_res (
    .va_i(va_i), .write_i(write_i), .hit_i(hit), .odd_i(odd),
    .half_mask_i(half_mask), .pfn_e_i(pfn_e), .pfn_o_i(pfn_o),
    .v_e_i(v_e), .v_o_i(v_o), .d_e_i(d_e), .d_o_i(d_o),
    .pa_o(pa_o), .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o), .status_o(st)
  );

  assign status_o = st;

  assert_nohit_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'd0) |-> (!rd_ok_o && !wr_ok_o && pa_o == '0));
  assert_read_no_modify_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !write_i |-> (status_o != 2'd3));
  assert_hit_offset_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0) |-> (rd_ok_o && pa_o[PAGE_SHIFT-1:0] == va_i[PAGE_SHIFT-1:0]));
  assert_store_hit_writable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0 && write_i) |-> wr_ok_o);
  assert_empty_miss_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |-> (status_o == 2'd1));
endmodule

// File: tb/sim_tlb_lookup.sv
module sim_tlb_lookup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        we = 1'b0;
  logic [2:0]  widx = '0;
  logic [18:0] w_vpn2 = '0;
  logic [7:0]  w_asid = '0;
  logic        w_glob = 1'b0;
  logic [15:0] w_pmask = '0;
  logic [19:0] w_pfn_e = '0, w_pfn_o = '0;
  logic        w_ve = 1'b0, w_de = 1'b0, w_vo = 1'b0, w_do = 1'b0;
  logic [31:0] va = '0;
  logic [7:0]  asid = '0;
  logic        wr = 1'b0;
  logic [31:0] pa;
  logic        rd_ok, wr_ok;
  logic [1:0]  st;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  tlb_lookup u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .widx_i(widx),
    .w_vpn2_i(w_vpn2), .w_asid_i(w_asid), .w_global_i(w_glob), .w_pmask_i(w_pmask),
    .w_pfn_even_i(w_pfn_e), .w_v_even_i(w_ve), .w_d_even_i(w_de),
    .w_pfn_odd_i(w_pfn_o), .w_v_odd_i(w_vo), .w_d_odd_i(w_do),
    .va_i(va), .asid_i(asid), .write_i(wr),
    .pa_o(pa), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .status_o(st)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic set_entry(input logic [2:0] idx, input logic [31:0] base, input logic [7:0] a,
                           input logic g, input logic [15:0] m,
                           input logic [19:0] pe, input logic ve, input logic de,
                           input logic [19:0] po, input logic vo, input logic dd);
    widx = idx; w_vpn2 = base[31:13]; w_asid = a; w_glob = g; w_pmask = m;
    w_pfn_e = pe; w_ve = ve; w_de = de; w_pfn_o = po; w_vo = vo; w_do = dd;
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] base, input logic [7:0] a,
                      input logic g, input logic [15:0] m,
                      input logic [19:0] pe, input logic ve, input logic de,
                      input logic [19:0] po, input logic vo, input logic dd);
    @(negedge clk);
    set_entry(idx, base, a, g, m, pe, ve, de, po, vo, dd);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic look(input string req, input logic [31:0] v, input logic [7:0] a, input logic w,
                      input logic [1:0] es, input logic [31:0] epa, input logic er, input logic ew);
    @(negedge clk);
    va = v; asid = a; wr = w;
    #1;
    chk({req, " status"}, 32'(st), 32'(es));
    chk({req, " pa"}, pa, epa);
    chk({req, " rd"}, 32'(rd_ok), 32'(er));
    chk({req, " wr"}, 32'(wr_ok), 32'(ew));
  endtask

  task automatic t_reset;
    look("R1 zero entry invalid", 32'h0000_1000, 8'h00, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
    look("R1 zero entry other id", 32'h0000_1000, 8'h05, 1'b0, 2'd1, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_basic;
    load(3'd2, 32'h0040_0000, 8'h11, 1'b0, 16'h0, 20'h12345, 1'b1, 1'b1, 20'h0ABCD, 1'b1, 1'b0);
    look("R7 even hit", 32'h0040_0123, 8'h11, 1'b0, 2'd0, 32'h1234_5123, 1'b1, 1'b1);
    look("R4 odd hit", 32'h0040_1456, 8'h11, 1'b0, 2'd0, 32'h0ABC_D456, 1'b1, 1'b0);
    look("R2 id mismatch", 32'h0040_0123, 8'h22, 1'b0, 2'd1, 32'h0, 1'b0, 1'b0);
    load(3'd3, 32'h0080_0000, 8'h55, 1'b1, 16'h0, 20'h00001, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    look("R2 global hit", 32'h0080_0010, 8'h99, 1'b0, 2'd0, 32'h0000_1010, 1'b1, 1'b1);
  endtask

  task automatic t_invalid;
    load(3'd4, 32'h00A0_0000, 8'h11, 1'b0, 16'h0, 20'h00555, 1'b0, 1'b1, 20'h00777, 1'b1, 1'b1);
    look("R5 invalid even", 32'h00A0_0040, 8'h11, 1'b0, 2'd2, 32'h0, 1'b0, 1'b0);
    look("R7 odd store hit", 32'h00A0_1FFF, 8'h11, 1'b1, 2'd0, 32'h0077_7FFF, 1'b1, 1'b1);
  endtask

  task automatic t_modify;
    look("R6 store clean", 32'h0040_1000, 8'h11, 1'b1, 2'd3, 32'h0, 1'b0, 1'b0);
    look("R6 load clean", 32'h0040_1000, 8'h11, 1'b0, 2'd0, 32'h0ABC_D000, 1'b1, 1'b0);
  endtask

  task automatic t_mask;
    load(3'd5, 32'h0100_0000, 8'h11, 1'b0, 16'h0003, 20'h20000, 1'b1, 1'b1, 20'h30000, 1'b1, 1'b1);
    look("R3 masked bit13", 32'h0100_2ABC, 8'h11, 1'b0, 2'd0, 32'h2000_2ABC, 1'b1, 1'b1);
    look("R4 odd 16k", 32'h0100_7004, 8'h11, 1'b0, 2'd0, 32'h3000_3004, 1'b1, 1'b1);
    look("R3 outside pair", 32'h0100_8000, 8'h11, 1'b0, 2'd1, 32'h0, 1'b0, 1'b0);
  endtask

  task automatic t_priority;
    load(3'd6, 32'h0200_0000, 8'h00, 1'b1, 16'h0, 20'h0BBBB, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    load(3'd1, 32'h0200_0000, 8'h00, 1'b1, 16'h0, 20'h0AAAA, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    look("R9 lowest wins", 32'h0200_0321, 8'h33, 1'b0, 2'd0, 32'h0AAA_A321, 1'b1, 1'b1);
    load(3'd1, 32'h0300_0000, 8'h00, 1'b1, 16'h0, 20'h0AAAA, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    look("R9 next in line", 32'h0200_0321, 8'h33, 1'b0, 2'd0, 32'h0BBB_B321, 1'b1, 1'b1);
  endtask

  task automatic t_write_port;
    @(negedge clk);
    set_entry(3'd7, 32'h0400_0000, 8'h00, 1'b1, 16'h0, 20'h04444, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    va = 32'h0400_0008; asid = 8'h01; wr = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 we low no effect", 32'(st), 32'd1);
    we = 1'b1;
    #1;
    chk("R10 not yet visible", 32'(st), 32'd1);
    @(posedge clk);
    #1;
    chk("R10 visible after edge", 32'(st), 32'd0);
    chk("R10 new pa", pa, 32'h0444_4008);
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_invalid();
    t_modify();
    t_mask();
    t_priority();
    t_write_port();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule